// File: doc/BRIEF.md
# Power-Up Strap Latch Controller

This block captures board-level configuration straps from pins that are shared between strap input and clock output duty. Right after a power cycle every shared pin is an input and the output drivers are off. A single strobe pin, the power-good level, decides when the strap levels are valid. When the strobe is first seen high, the pin levels are frozen into an internal register and the pins are turned around so that they drive clocks. From then on, the same strobe pin is read as an active-low power-down request.

The controller then sequences the clock outputs. After a capture, and again after every release of power-down, it holds a stabilization wait that is counted on the reference clock before it enables the outputs. A disabled or sleeping differential pair drives both of its legs low. Two flags decode the captured frequency code: one marks the code that puts the CPU outputs into high impedance, and the other marks the reserved code. The strobe and the strap pins are asynchronous to the reference clock, so they pass through a shared synchronizer. That keeps the strap levels aligned with the strobe edge that samples them.

Top module: `strap_latch_ctrl`

## Requirements
- R1: In reset, and on the first cycle after it, `strap_oe`, `stab_wait`, `clk_out_en`, `pwr_down`, `cpu_hiz` and `fs_reserved` are 0, `strap_q` is 0, and every `diff_t`/`diff_c` bit is 0.
- R2: While the strobe has stayed low since reset, the pins remain inputs (`strap_oe`=0) and `strap_q` stays 0, however the strap pins toggle.
- R3: When the strobe goes high, `strap_q` takes the strap pin levels and both `strap_oe` and `stab_wait` become 1. These changes appear on the third rising clock edge after the strobe change, because of the two synchronizer stages.
- R4: `stab_wait` stays high for exactly `STAB_CYC` cycles. It then falls on the same edge where `clk_out_en` rises.
- R5: While `clk_out_en` is 1 and `cpu_hiz` is 0, `diff_t` equals `diff_src` and `diff_c` equals `~diff_src`. Otherwise both buses are all zero.
- R6: A strobe low after a capture sets `pwr_down` and clears `clk_out_en` on the third edge. `strap_oe` stays 1 and `strap_q` is unchanged.
- R7: A strobe high after power-down restarts a full `STAB_CYC` wait before `clk_out_en` returns. The straps are not sampled again, so `strap_q` keeps its first value even if the pins differ.
- R8: A strobe low during the stabilization wait also enters power-down, and `clk_out_en` stays 0.
- R9: `cpu_hiz` is 1 exactly when a capture has occurred and `strap_q[2:0]` is 3'b000. While it is 1, the differential pairs stay low.
- R10: `fs_reserved` is 1 exactly when a capture has occurred and `strap_q[2:0]` is 3'b101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| pg_strobe | input | 1 | Shared strobe pin: strap-valid level, then active-low power-down |
| strap_pin | input | STRAP_W | Levels seen on the shared strap pins |
| diff_src | input | N_DIFF | Free-running differential clock sources |
| strap_oe | output | 1 | 1 = shared pins drive clocks, 0 = pins are inputs |
| strap_q | output | STRAP_W | Latched strap code (bits 2:0 = frequency select) |
| stab_wait | output | 1 | Stabilization wait in progress |
| clk_out_en | output | 1 | Clock outputs valid and enabled |
| pwr_down | output | 1 | Low-power state active |
| cpu_hiz | output | 1 | Captured code requests CPU outputs in high impedance |
| fs_reserved | output | 1 | Captured code is the reserved value |
| diff_t | output | N_DIFF | True legs of the gated differential pairs |
| diff_c | output | N_DIFF | Complement legs of the gated differential pairs |

## Verification
The hardest situation to reach from the ports is a wake-up from power-down while the strap pins show a code different from the one captured. That is the only stimulus that can expose a second, unwanted sampling of the straps. The bench captures one code, drops the strobe, changes the pins, raises the strobe again, and then checks both the retained code and the full restarted wait. A strobe drop in the middle of the wait is also driven, so that the wait-to-sleep path is covered apart from the run-to-sleep path.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;
  typedef enum logic [1:0] {
    PH_STRAP  = 2'd0,
    PH_SETTLE = 2'd1,
    PH_RUN    = 2'd2,
    PH_SLEEP  = 2'd3
  } phase_t;

  localparam logic [2:0] FS_CODE_HIZ  = 3'b000;
  localparam logic [2:0] FS_CODE_RSVD = 3'b101;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
  parameter int LIMIT = 42954
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R4
endmodule

// File: rtl/strap_phase_fsm.sv
module strap_phase_fsm
  import strap_latch_pkg::*;
#(
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe_s,
  input  logic [STRAP_W-1:0] pins_s,
  input  logic               settle_done,
  output phase_t             phase,
  output logic [STRAP_W-1:0] strap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_STRAP;
      strap_q <= '0;
    end else begin
      case (phase)
        PH_STRAP: if (strobe_s) begin
          strap_q <= pins_s;
          phase   <= PH_SETTLE;
        end
        PH_SETTLE: begin
          if (!strobe_s)        phase <= PH_SLEEP;
          else if (settle_done) phase <= PH_RUN;
        end
        PH_RUN:   if (!strobe_s) phase <= PH_SLEEP;
        PH_SLEEP: if (strobe_s)  phase <= PH_SETTLE;
        default:  phase <= PH_STRAP;
      endcase
    end
  end

  AST_NO_RESAMPLE: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_STRAP) |=> $stable(strap_q)); // R7
  AST_NO_RETURN_TO_STRAP: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_STRAP) |=> (phase != PH_STRAP)); // R6
  AST_RUN_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) && ($past(phase) != PH_RUN) |-> ($past(phase) == PH_SETTLE)); // R4
endmodule

// File: rtl/strap_diff_gate.sv
module strap_diff_gate #(
  parameter int N = 7
) (
  input  logic         en,
  input  logic [N-1:0] src,
  output logic [N-1:0] out_t,
  output logic [N-1:0] out_c
);
  for (genvar g = 0; g < N; g++) begin : g_pair
    assign out_t[g] = en &  src[g];
    assign out_c[g] = en & ~src[g];
  end
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
  import strap_latch_pkg::*;
#(
  parameter int STRAP_W     = 3,
  parameter int N_DIFF      = 7,
  parameter int STAB_CYC    = 42954,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pg_strobe,
  input  logic [STRAP_W-1:0] strap_pin,
  input  logic [N_DIFF-1:0]  diff_src,
  output logic               strap_oe,
  output logic [STRAP_W-1:0] strap_q,
  output logic               stab_wait,
  output logic               clk_out_en,
  output logic               pwr_down,
  output logic               cpu_hiz,
  output logic               fs_reserved,
  output logic [N_DIFF-1:0]  diff_t,
  output logic [N_DIFF-1:0]  diff_c
);
  localparam int SW = STRAP_W + 1;

  logic [SW-1:0]      sync_q;
  logic               strobe_s;
  logic [STRAP_W-1:0] pins_s;
  logic               settle_done;
  phase_t             phase;

  strap_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({pg_strobe, strap_pin}), .q(sync_q)
  );
  assign strobe_s = sync_q[SW-1];
  assign pins_s   = sync_q[STRAP_W-1:0];

  strap_settle_timer #(.LIMIT(STAB_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(phase == PH_SETTLE), .done(settle_done)
  );

  strap_phase_fsm #(.STRAP_W(STRAP_W)) u_fsm (
    .clk(clk), .rst(rst), .strobe_s(strobe_s), .pins_s(pins_s),
    .settle_done(settle_done), .phase(phase), .strap_q(strap_q)
  );

  assign strap_oe    = (phase != PH_STRAP);
  assign stab_wait   = (phase == PH_SETTLE);
  assign clk_out_en  = (phase == PH_RUN);
  assign pwr_down    = (phase == PH_SLEEP);
  assign cpu_hiz     = strap_oe && (strap_q[2:0] == FS_CODE_HIZ);
  assign fs_reserved = strap_oe && (strap_q[2:0] == FS_CODE_RSVD);

  strap_diff_gate #(.N(N_DIFF)) u_gate (
    .en(clk_out_en && !cpu_hiz), .src(diff_src), .out_t(diff_t), .out_c(diff_c)
  );

  AST_INPUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strap_oe |-> (strap_q == '0)); // R2
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (diff_t == '0 && diff_c == '0)); // R6
  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (rst)
    cpu_hiz |-> (diff_t == '0 && diff_c == '0)); // R9
  AST_EN_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out_en) |-> $past(stab_wait)); // R4
endmodule

// File: tb/strap_latch_ctrl_bench.sv
module strap_latch_ctrl_bench;
  localparam int STRAP_W = 3;
  localparam int N_DIFF  = 7;
  localparam int STAB    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg_strobe = 1'b0;
  logic [STRAP_W-1:0] strap_pin = '0;
  logic [N_DIFF-1:0]  diff_src = '0;
  logic strap_oe, stab_wait, clk_out_en, pwr_down, cpu_hiz, fs_reserved;
  logic [STRAP_W-1:0] strap_q;
  logic [N_DIFF-1:0]  diff_t, diff_c;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  strap_latch_ctrl #(.STRAP_W(STRAP_W), .N_DIFF(N_DIFF), .STAB_CYC(STAB)) u_strap_latch_ctrl (
    .clk(clk), .rst(rst), .pg_strobe(pg_strobe), .strap_pin(strap_pin),
    .diff_src(diff_src), .strap_oe(strap_oe), .strap_q(strap_q),
    .stab_wait(stab_wait), .clk_out_en(clk_out_en), .pwr_down(pwr_down),
    .cpu_hiz(cpu_hiz), .fs_reserved(fs_reserved), .diff_t(diff_t), .diff_c(diff_c)
  );

  // Entry = {pins[2:0], expected cpu_hiz, expected fs_reserved}
  localparam logic [4:0] VEC [5] = '{
    {3'b000, 1'b1, 1'b0},
    {3'b101, 1'b0, 1'b1},
    {3'b011, 1'b0, 1'b0},
    {3'b110, 1'b0, 1'b0},
    {3'b111, 1'b0, 1'b0}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    pg_strobe = 1'b0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic chk_pairs(input logic en, input string req);
    logic [N_DIFF-1:0] et, ec;
    et = en ? diff_src : '0;
    ec = en ? ~diff_src : '0;
    chk(diff_t == et, req, diff_t, et);
    chk(diff_c == ec, req, diff_c, ec);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk({strap_oe, stab_wait, clk_out_en, pwr_down, cpu_hiz, fs_reserved} == 6'b0,
        "R1 flags", {strap_oe, stab_wait, clk_out_en, pwr_down, cpu_hiz, fs_reserved}, 0);
    chk(strap_q == '0, "R1 strap_q", strap_q, 0);
    diff_src = 7'h55;
    chk_pairs(1'b0, "R1 pairs");

    // R2 pins toggle while strobe low
    for (int i = 0; i < 10; i++) begin
      strap_pin = STRAP_W'(i);
      step(1);
    end
    chk(strap_oe == 1'b0, "R2 oe", strap_oe, 0);
    chk(strap_q == '0, "R2 strap_q", strap_q, 0);

    // Table walk: capture, decode, stabilization, gating
    for (int v = 0; v < 5; v++) begin
      do_reset();
      strap_pin = VEC[v][4:2];
      diff_src  = N_DIFF'(7'h2b + v);
      pg_strobe = 1'b1;
      step(2);
      chk(strap_oe == 1'b0, "R3 not before third edge", strap_oe, 0);
      step(1);
      chk(strap_q == VEC[v][4:2], "R3 capture", strap_q, VEC[v][4:2]);
      chk(strap_oe && stab_wait, "R3 oe/wait", {strap_oe, stab_wait}, 2'b11);
      chk(cpu_hiz == VEC[v][1], "R9 hiz flag", cpu_hiz, VEC[v][1]);
      chk(fs_reserved == VEC[v][0], "R10 reserved flag", fs_reserved, VEC[v][0]);
      step(STAB - 1);
      chk(stab_wait == 1'b1 && clk_out_en == 1'b0, "R4 wait last cycle",
          {stab_wait, clk_out_en}, 2'b10);
      step(1);
      chk(stab_wait == 1'b0 && clk_out_en == 1'b1, "R4 enable edge",
          {stab_wait, clk_out_en}, 2'b01);
      chk_pairs(!VEC[v][1], VEC[v][1] ? "R9 pairs held low" : "R5 pairs follow src");
      diff_src = ~diff_src;
      #1;
      chk_pairs(!VEC[v][1], "R5 pairs after src change");
    end

    // R6 power-down from run (last table entry is running, code 111)
    pg_strobe = 1'b0;
    strap_pin = 3'b010;
    step(2);
    chk(clk_out_en == 1'b1, "R6 still running before third edge", clk_out_en, 1);
    step(1);
    chk(pwr_down && !clk_out_en, "R6 sleep", {pwr_down, clk_out_en}, 2'b10);
    chk(strap_oe == 1'b1, "R6 oe kept", strap_oe, 1);
    chk(strap_q == 3'b111, "R6 strap_q kept", strap_q, 3'b111);
    chk_pairs(1'b0, "R6 pairs low");

    // R7 wake with different pins: no resample, full wait
    pg_strobe = 1'b1;
    step(3);
    chk(stab_wait && !pwr_down, "R7 wait restarts", {stab_wait, pwr_down}, 2'b10);
    chk(strap_q == 3'b111, "R7 no resample", strap_q, 3'b111);
    step(STAB - 1);
    chk(clk_out_en == 1'b0, "R7 still waiting", clk_out_en, 0);
    step(1);
    chk(clk_out_en == 1'b1, "R7 enabled after full wait", clk_out_en, 1);
    chk(strap_q == 3'b111, "R7 strap_q after wake", strap_q, 3'b111);

    // R8 strobe drop during the wait
    do_reset();
    strap_pin = 3'b100;
    pg_strobe = 1'b1;
    step(3 + 3);
    pg_strobe = 1'b0;
    step(3);
    chk(pwr_down && !stab_wait, "R8 sleep from wait", {pwr_down, stab_wait}, 2'b10);
    step(STAB + 2);
    chk(clk_out_en == 1'b0, "R8 stays disabled", clk_out_en, 0);
    chk(strap_q == 3'b100, "R8 strap_q kept", strap_q, 3'b100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule